// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block produces the timing strobes for a PCM audio serial port. Two clock-enable pulse streams come in. One is an auxiliary source and the other is a 48 MHz source, both already reduced to single-cycle enables in the system clock domain. A select input chooses which stream is counted. A programmable bit prescaler counts the selected pulses and issues one bit-clock enable every (bitDiv + 1) of them. A second programmable prescaler counts those bit-clock enables and marks every (frameDiv + 1)-th one as the start of a frame.

The frame prescaler is cascaded behind the bit prescaler, so the frame length is a number of bit clocks. It keeps running even when the serial port takes its frame sync from outside, and it must be programmed in that case too. With a 1024 kHz bit clock and 128 bits per frame, the frame rate is 8 kHz. New divider values are taken only at a terminal count, so a period that is already running is never cut short.

Top module: `audio_clkgen`

## Requirements
- R1: While rstN is low, bitClkEn and frameSync are 0. Reset clears both active divider settings to zero, so the first selected pulse after reset produces a bit-clock enable and a frame sync.
- R2: srcSel = 0 counts auxClkEn and srcSel = 1 counts hsClkEn. Pulses on the enable that is not selected have no effect on the outputs or on the counting.
- R3: bitClkEn is a one-cycle pulse issued for every (active bit divider + 1)-th selected pulse.
- R4: frameSync pulses on every (active frame divider + 1)-th bit-clock enable, starting with the bit-clock enable on which the frame counter wraps to zero.
- R5: bitDiv is 8 bits wide, so it divides by any value from 1 to 256.
- R6: frameDiv is 7 bits wide, so a frame holds from 1 to 128 bit clocks.
- R7: A new bitDiv value takes effect only at the bit counter's terminal count. The bit period in progress keeps its old length.
- R8: A new frameDiv value takes effect only at the frame counter's terminal count. The frame in progress keeps its old length.
- R9: frameSync is never high unless bitClkEn is high in the same cycle.
- R10: Both outputs are registered. They rise in the cycle after the clock edge that samples the selected pulse which completes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcSel | input | 1 | Source select: 0 = auxiliary, 1 = 48 MHz |
| bitDiv | input | 8 | Bit prescaler setting (divide by value + 1) |
| frameDiv | input | 7 | Frame prescaler setting (bit clocks per frame minus 1) |
| auxClkEn | input | 1 | Enable pulses of the auxiliary source |
| hsClkEn | input | 1 | Enable pulses of the 48 MHz source |
| bitClkEn | output | 1 | One-cycle bit-clock enable |
| frameSync | output | 1 | One-cycle frame-start pulse, coincident with bitClkEn |

## Verification
Each output is due exactly one clock after the rising edge that samples the selected enable pulse which completes a count. The bench drives inputs on the falling edge. On the next falling edge, after one rising edge, it compares the outputs against a count-based model that was fed the inputs held over that edge. Because of this, divider writes and source switches made mid-count are checked in the very cycle they are due, including the terminal count at which a new setting is first used.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

  // Strobes passed from the control decode to the counting datapath.
  typedef struct packed {
    logic srcTick;    // selected source pulse this cycle
    logic bitWrap;    // bit counter at terminal count on a source pulse
    logic frameWrap;  // frame counter at terminal count on a bit wrap
  } clkStrobes_t;

endpackage

// File: rtl/audio_clkgen_ctrl.sv
module audio_clkgen_ctrl
  import audio_clkgen_pkg::*;
#(
  parameter int BIT_W   = 8,
  parameter int FRAME_W = 7
) (
  input  logic               srcSel,
  input  logic               auxClkEn,
  input  logic               hsClkEn,
  input  logic [BIT_W-1:0]   bitCnt,
  input  logic [BIT_W-1:0]   bitDivAct,
  input  logic [FRAME_W-1:0] frameCnt,
  input  logic [FRAME_W-1:0] frameDivAct,
  output clkStrobes_t        strobes
);

  logic bitTerminal;
  logic frameTerminal;

  always_comb begin
    bitTerminal   = (bitCnt == bitDivAct);
    frameTerminal = (frameCnt == frameDivAct);
    strobes.srcTick   = srcSel ? hsClkEn : auxClkEn;
    strobes.bitWrap   = strobes.srcTick && bitTerminal;
    strobes.frameWrap = strobes.bitWrap && frameTerminal;
  end

endmodule

// File: rtl/audio_clkgen_dp.sv
module audio_clkgen_dp
  import audio_clkgen_pkg::*;
#(
  parameter int BIT_W   = 8,
  parameter int FRAME_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  clkStrobes_t        strobes,
  input  logic [BIT_W-1:0]   bitDiv,
  input  logic [FRAME_W-1:0] frameDiv,
  output logic [BIT_W-1:0]   bitCnt,
  output logic [BIT_W-1:0]   bitDivAct,
  output logic [FRAME_W-1:0] frameCnt,
  output logic [FRAME_W-1:0] frameDivAct,
  output logic               bitClkEn,
  output logic               frameSync
);

  // Bit prescaler: counts selected source pulses; reloads its divider on wrap.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      bitDivAct <= '0;
    end else if (strobes.srcTick) begin
      if (strobes.bitWrap) begin
        bitCnt    <= '0;
        bitDivAct <= bitDiv;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // Frame prescaler: counts bit wraps; reloads its divider on frame wrap.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt    <= '0;
      frameDivAct <= '0;
    end else if (strobes.bitWrap) begin
      if (strobes.frameWrap) begin
        frameCnt    <= '0;
        frameDivAct <= frameDiv;
      end else begin
        frameCnt <= frameCnt + 1'b1;
      end
    end
  end

  // Registered output strobes.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitClkEn  <= 1'b0;
      frameSync <= 1'b0;
    end else begin
      bitClkEn  <= strobes.bitWrap;
      frameSync <= strobes.frameWrap;
    end
  end

  // R3: the bit counter never passes its active terminal count
  a_r3_bit_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= bitDivAct);

  // R4: the frame counter never passes its active terminal count
  a_r4_frame_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    frameCnt <= frameDivAct);

  // R7: the active bit divider changes only together with a bit-clock enable
  a_r7_bit_reload_at_wrap: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bitDivAct) |-> bitClkEn);

  // R8: the active frame divider changes only together with a frame sync
  a_r8_frame_reload_at_wrap: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(frameDivAct) |-> frameSync);

  // R9: a frame sync always coincides with a bit-clock enable
  a_r9_sync_with_bit: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |-> bitClkEn);

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audio_clkgen_pkg::*;
#(
  parameter int BIT_W   = 8,
  parameter int FRAME_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               srcSel,
  input  logic [BIT_W-1:0]   bitDiv,
  input  logic [FRAME_W-1:0] frameDiv,
  input  logic               auxClkEn,
  input  logic               hsClkEn,
  output logic               bitClkEn,
  output logic               frameSync
);

  clkStrobes_t        strobes;
  logic [BIT_W-1:0]   bitCnt;
  logic [BIT_W-1:0]   bitDivAct;
  logic [FRAME_W-1:0] frameCnt;
  logic [FRAME_W-1:0] frameDivAct;

  audio_clkgen_ctrl #(.BIT_W(BIT_W), .FRAME_W(FRAME_W)) u_ctrl (
    .srcSel      (srcSel),
    .auxClkEn    (auxClkEn),
    .hsClkEn     (hsClkEn),
    .bitCnt      (bitCnt),
    .bitDivAct   (bitDivAct),
    .frameCnt    (frameCnt),
    .frameDivAct (frameDivAct),
    .strobes     (strobes)
  );

  audio_clkgen_dp #(.BIT_W(BIT_W), .FRAME_W(FRAME_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .bitDiv      (bitDiv),
    .frameDiv    (frameDiv),
    .bitCnt      (bitCnt),
    .bitDivAct   (bitDivAct),
    .frameCnt    (frameCnt),
    .frameDivAct (frameDivAct),
    .bitClkEn    (bitClkEn),
    .frameSync   (frameSync)
  );

  // R2: without a pulse on the selected source, no bit-clock enable follows
  a_r2_no_tick_without_source: assert property (@(posedge clk) disable iff (!rstN)
    !(srcSel ? hsClkEn : auxClkEn) |=> !bitClkEn);

endmodule

// File: tb/audio_clkgen_bench.sv
`timescale 1ns/1ps
module audio_clkgen_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       srcSel = 1'b0;
  logic [7:0] bitDiv = '0;
  logic [6:0] frameDiv = '0;
  logic       auxClkEn = 1'b0;
  logic       hsClkEn = 1'b0;
  logic       bitClkEn;
  logic       frameSync;

  int checks = 0;
  int fails = 0;

  // Requirement-level model state
  int mBitCnt = 0, mBitDiv = 0, mFrCnt = 0, mFrDiv = 0;

  always #5 clk = ~clk;

  audio_clkgen u_audio_clkgen (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .bitDiv(bitDiv),
    .frameDiv(frameDiv), .auxClkEn(auxClkEn), .hsClkEn(hsClkEn),
    .bitClkEn(bitClkEn), .frameSync(frameSync)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // One cycle: wait for the falling edge, model the rising edge just passed
  // using the inputs held across it, then compare the registered outputs.
  task automatic step(string req);
    int eb, ef, en;
    @(negedge clk);
    eb = 0; ef = 0;
    if (!rstN) begin
      mBitCnt = 0; mBitDiv = 0; mFrCnt = 0; mFrDiv = 0;
    end else begin
      en = srcSel ? int'(hsClkEn) : int'(auxClkEn);
      if (en != 0) begin
        if (mBitCnt == mBitDiv) begin
          eb = 1; mBitCnt = 0; mBitDiv = int'(bitDiv);
          if (mFrCnt == mFrDiv) begin
            ef = 1; mFrCnt = 0; mFrDiv = int'(frameDiv);
          end else mFrCnt++;
        end else mBitCnt++;
      end
    end
    chk(req, "bitClkEn", int'(bitClkEn), eb);
    chk(req, "frameSync", int'(frameSync), ef);
    chk("R9", "sync without bit clock", int'(frameSync && !bitClkEn), 0);
  endtask

  task automatic doReset(int n);
    rstN = 1'b0;
    for (int i = 0; i < n; i++) step("R1");
    rstN = 1'b1;
  endtask

  task automatic randEn(int hsAlways);
    auxClkEn = ($urandom % 3) == 0;
    hsClkEn  = (hsAlways != 0) ? 1'b1 : (($urandom % 2) == 0);
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R1: outputs low during reset, first selected pulse gives both strobes
    doReset(3);
    srcSel = 1'b1; bitDiv = 8'd4; frameDiv = 7'd2; hsClkEn = 1'b1;
    step("R1");
    step("R1");

    // R3 R4 R10: sweep of small divider settings on both sources
    for (int s = 0; s < 2; s++)
      for (int bd = 0; bd < 5; bd++)
        for (int fd = 0; fd < 4; fd++) begin
          srcSel = s[0]; bitDiv = 8'(bd); frameDiv = 7'(fd);
          doReset(2);
          for (int c = 0; c < 80; c++) begin
            randEn(0);
            step("R3 R4 R10");
          end
        end

    // R2: only the unselected source pulses, nothing must happen
    doReset(2);
    bitDiv = 8'd0; frameDiv = 7'd0;
    srcSel = 1'b0; auxClkEn = 1'b0; hsClkEn = 1'b1;
    for (int c = 0; c < 20; c++) step("R2");
    srcSel = 1'b1; hsClkEn = 1'b0; auxClkEn = 1'b1;
    for (int c = 0; c < 20; c++) step("R2");
    // R2: source switching mid-count with noise on both enables
    bitDiv = 8'd3; frameDiv = 7'd2;
    for (int c = 0; c < 600; c++) begin
      if (c % 7 == 0) srcSel = ~srcSel;
      randEn(0);
      step("R2");
    end

    // R5: largest bit divider (divide by 256)
    doReset(2);
    srcSel = 1'b1; bitDiv = 8'd255; frameDiv = 7'd1;
    for (int c = 0; c < 800; c++) begin randEn(1); step("R5"); end

    // R6: 128 bit clocks per frame
    doReset(2);
    srcSel = 1'b1; bitDiv = 8'd7; frameDiv = 7'd127;
    for (int c = 0; c < 2200; c++) begin randEn(1); step("R6"); end

    // R7: bit divider change mid-period waits for the terminal count
    doReset(2);
    srcSel = 1'b1; bitDiv = 8'd3; frameDiv = 7'd0; hsClkEn = 1'b1;
    for (int c = 0; c < 7; c++) step("R7");
    bitDiv = 8'd1;
    for (int c = 0; c < 20; c++) step("R7");
    bitDiv = 8'd5;
    for (int c = 0; c < 3; c++) step("R7");
    bitDiv = 8'd0;
    for (int c = 0; c < 20; c++) step("R7");

    // R8: frame divider change mid-frame waits for the frame wrap
    doReset(2);
    srcSel = 1'b0; bitDiv = 8'd1; frameDiv = 7'd3; auxClkEn = 1'b1;
    for (int c = 0; c < 5; c++) step("R8");
    frameDiv = 7'd1;
    for (int c = 0; c < 30; c++) step("R8");
    frameDiv = 7'd6;
    for (int c = 0; c < 3; c++) step("R8");
    frameDiv = 7'd2;
    for (int c = 0; c < 40; c++) step("R8");

    // R7 R8: random divider writes at arbitrary times
    for (int c = 0; c < 3000; c++) begin
      if ($urandom % 23 == 0) bitDiv = 8'($urandom % 6);
      if ($urandom % 31 == 0) frameDiv = 7'($urandom % 5);
      randEn(0);
      step("R7 R8");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule